// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache with LRU Replacement

This block is a read-only cache that sits between a requester that fetches 32-bit words and a slower memory that returns whole lines. Each set has four ways. Each way holds a valid flag, a tag and an eight-word line. A request address picks one set through its index field. All four stored tags of that set are compared with the request tag in parallel. A one-hot hit vector then steers the matching way's word to the response register.

When no way matches, the cache drops its ready signal and the requester is held off. The cache then chooses a way to replace, preferring an empty way and otherwise the one used least recently. It requests the line from memory and writes the returned words as they arrive. Once the eighth word has been written, the cache repeats the lookup of the stalled request, which now hits. Recency is tracked per set with one small age counter per way.

Top module: `setassoc_icache`

## Requirements
- R1: Address fields are: bits 4:2 select the word in the line, bits 10:5 select one of 64 sets, and bits 31:11 are the tag. Bits 1:0 have no effect. A line held in one set never answers a request for a different set or a different tag.
- R2: A request accepted (reqValid and reqReady high at a clock edge) that hits produces respValid for one cycle, with the addressed word, on the following edge. fillReq stays low.
- R3: A request that misses raises fillReq and lowers reqReady from the edge after acceptance. fillAddr holds the request's bits 31:5 steady until the line is complete.
- R4: Line words arrive in order, word 0 first. Each word is marked by one fillValid cycle, and idle gaps between words are allowed. The way only becomes valid after the eighth word.
- R5: On the edge after the eighth word is taken, the stalled request is looked up again. On the edge after that, it responds with the word it originally addressed.
- R6: While a set still has an empty way, a miss fills the lowest-numbered empty way, and no valid line is displaced.
- R7: When all four ways are valid, a miss replaces the way whose last hit or fill is the oldest in that set.
- R8: After reset, reqReady is high, respValid and fillReq are low, and every line is empty, so the first access to any address misses.
- R9: While reqReady is low, reqValid and reqAddr are ignored. A request held high through a fill is taken only after the stalled request has responded, and the responses come out in request order.
- R10: fillValid pulses while no line is being fetched change no stored data and raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents an address |
| reqAddr | input | 32 | Byte address of the requested word |
| reqReady | output | 1 | Cache can take a request this cycle |
| respValid | output | 1 | Response word valid, one cycle per request |
| respData | output | 32 | Returned word |
| fillReq | output | 1 | Line fetch in progress |
| fillAddr | output | 27 | Line address being fetched (address bits 31:5) |
| fillValid | input | 1 | One line word presented by memory |
| fillData | input | 32 | Line word, in word order |

## Verification
Two functions meet at the end of a line fill: the stalled request is replayed, and a new request from the requester is already waiting. The bench provokes this by holding reqValid high with a second address, one that will hit, during a whole burst. It checks that reqReady stays low for the whole burst. It then checks that the replay answer arrives first and the waiting request is answered on the next edge with no fetch. A reference model that keeps a timestamp of the last use of each way predicts every hit or miss. It checks each fetch against that prediction, so a wrong choice of victim shows up as a fetch that should not happen or a fetch that is missing.

// File: rtl/sacache_pkg.sv
package sacache_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int NUM_WAYS   = 4;
  localparam int NUM_SETS   = 64;
  localparam int LINE_WORDS = 8;
  localparam int BYTE_OFF_W = 2;

  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_OFF_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int AGE_W  = WAY_W;

  typedef struct packed {
    logic              useSaved;   // look up the stalled address
    logic              respLoad;   // load response register, touch LRU
    logic              missStart;  // latch address and victim, clear victim valid
    logic              fillWr;     // write one fill word
    logic              fillLast;   // final word: set tag and valid
    logic [WSEL_W-1:0] fillWord;   // word position of current fill beat
  } ctrl_strb_t;
endpackage

// File: rtl/sacache_lru.sv
module sacache_lru
  import sacache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_W-1:0]    lookIdx,
  input  logic [NUM_WAYS-1:0] validSet,
  input  logic                touch,
  input  logic [WAY_W-1:0]    touchWay,
  output logic [WAY_W-1:0]    victimWay
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_WAYS - 1);

  logic [NUM_WAYS-1:0][AGE_W-1:0] ageArr [NUM_SETS];
  logic [NUM_WAYS-1:0][AGE_W-1:0] setAges;

  assign setAges = ageArr[lookIdx];

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (setAges[w] == OLDEST) victimWay = WAY_W'(w);
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!validSet[w]) victimWay = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          ageArr[s][w] <= AGE_W'(w);
    end else if (touch) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touchWay)
          ageArr[lookIdx][w] <= '0;
        else if (setAges[w] < setAges[touchWay])
          ageArr[lookIdx][w] <= setAges[w] + AGE_W'(1);
      end
    end
  end

  function automatic logic agesDistinct(input logic [NUM_WAYS-1:0][AGE_W-1:0] a);
    logic [NUM_WAYS-1:0] seen;
    seen = '0;
    for (int w = 0; w < NUM_WAYS; w++) seen[a[w]] = 1'b1;
    return &seen;
  endfunction

  // R7
  age_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    agesDistinct(setAges));
endmodule

// File: rtl/sacache_ctrl.sv
module sacache_ctrl
  import sacache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lookupHit,
  input  logic       fillValid,
  output ctrl_strb_t strb,
  output logic       reqReady,
  output logic       fillReq
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_REPLAY} state_t;

  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  state_t            state, stateNxt;
  logic [WSEL_W-1:0] wordCnt;

  always_comb begin
    strb          = '0;
    strb.fillWord = wordCnt;
    strb.useSaved = (state == ST_REPLAY);
    stateNxt      = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (lookupHit) strb.respLoad = 1'b1;
        else begin
          strb.missStart = 1'b1;
          stateNxt       = ST_FILL;
        end
      end
      ST_FILL: if (fillValid) begin
        strb.fillWr = 1'b1;
        if (wordCnt == LAST_WORD) begin
          strb.fillLast = 1'b1;
          stateNxt      = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        strb.respLoad = 1'b1;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      state <= stateNxt;
      if (strb.missStart)   wordCnt <= '0;
      else if (strb.fillWr) wordCnt <= wordCnt + WSEL_W'(1);
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign fillReq  = (state == ST_FILL);

  // R5
  replay_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPLAY) |-> lookupHit);
endmodule

// File: rtl/sacache_datapath.sv
module sacache_datapath
  import sacache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strb_t          strb,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   fillData,
  input  logic [WAY_W-1:0]    victimWay,
  output logic [IDX_W-1:0]    lookIdx,
  output logic [NUM_WAYS-1:0] validSet,
  output logic                lookupHit,
  output logic [WAY_W-1:0]    hitWayIdx,
  output logic                respValid,
  output logic [DATA_W-1:0]   respData,
  output logic [LINE_W-1:0]   fillAddr
);
  logic [ADDR_W-1:0]   savedAddr;
  logic [WAY_W-1:0]    fillWay;
  logic [ADDR_W-1:0]   lookAddr;
  logic [TAG_W-1:0]    lookTag;
  logic [WSEL_W-1:0]   lookWord;
  logic [IDX_W-1:0]    fillIdx;
  logic [NUM_WAYS-1:0] wayHit;
  logic [DATA_W-1:0]   wayWord [NUM_WAYS];
  logic [DATA_W-1:0]   hitWord;
  logic                unusedByteBits;

  logic [NUM_WAYS-1:0] validArr [NUM_SETS];
  logic [TAG_W-1:0]    tagArr   [NUM_SETS][NUM_WAYS];
  logic [DATA_W-1:0]   dataArr  [NUM_SETS][NUM_WAYS][LINE_WORDS];

  assign lookAddr       = strb.useSaved ? savedAddr : reqAddr;
  assign lookTag        = lookAddr[ADDR_W-1 -: TAG_W];
  assign lookIdx        = lookAddr[OFF_W +: IDX_W];
  assign lookWord       = lookAddr[BYTE_OFF_W +: WSEL_W];
  assign unusedByteBits = ^{lookAddr[BYTE_OFF_W-1:0], savedAddr[OFF_W-1:0]};
  assign fillIdx        = savedAddr[OFF_W +: IDX_W];
  assign fillAddr       = savedAddr[ADDR_W-1:OFF_W];
  assign validSet       = validArr[lookIdx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign wayHit[w]  = validArr[lookIdx][w] && (tagArr[lookIdx][w] == lookTag);
    assign wayWord[w] = dataArr[lookIdx][w][lookWord];
  end

  assign lookupHit = |wayHit;

  always_comb begin
    hitWord   = '0;
    hitWayIdx = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hitWord = hitWord | (wayWord[w] & {DATA_W{wayHit[w]}});
      if (wayHit[w]) hitWayIdx = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
      savedAddr <= '0;
      fillWay   <= '0;
      for (int s = 0; s < NUM_SETS; s++) validArr[s] <= '0;
    end else begin
      respValid <= strb.respLoad;
      if (strb.respLoad) respData <= hitWord;
      if (strb.missStart) begin
        savedAddr                   <= reqAddr;
        fillWay                     <= victimWay;
        validArr[lookIdx][victimWay] <= 1'b0;
      end
      if (strb.fillLast) validArr[fillIdx][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillWr)   dataArr[fillIdx][fillWay][strb.fillWord] <= fillData;
    if (strb.fillLast) tagArr[fillIdx][fillWay] <= savedAddr[ADDR_W-1 -: TAG_W];
  end

  // R1
  onehot_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit));

  // R4
  valid_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillWr && !strb.fillLast) |=> !validArr[fillIdx][fillWay]);
endmodule

// File: rtl/setassoc_icache.sv
module setassoc_icache
  import sacache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              fillReq,
  output logic [LINE_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [DATA_W-1:0] fillData
);
  ctrl_strb_t          strb;
  logic                lookupHit;
  logic [IDX_W-1:0]    lookIdx;
  logic [NUM_WAYS-1:0] validSet;
  logic [WAY_W-1:0]    hitWayIdx;
  logic [WAY_W-1:0]    victimWay;

  sacache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lookupHit(lookupHit),
    .fillValid(fillValid), .strb(strb), .reqReady(reqReady), .fillReq(fillReq)
  );

  sacache_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .fillData(fillData),
    .victimWay(victimWay), .lookIdx(lookIdx), .validSet(validSet),
    .lookupHit(lookupHit), .hitWayIdx(hitWayIdx), .respValid(respValid),
    .respData(respData), .fillAddr(fillAddr)
  );

  sacache_lru u_lru (
    .clk(clk), .rstN(rstN), .lookIdx(lookIdx), .validSet(validSet),
    .touch(strb.respLoad), .touchWay(hitWayIdx), .victimWay(victimWay)
  );

  // R2
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (respValid ^ fillReq));

  // R3
  fill_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && $past(fillReq)) |-> $stable(fillAddr));

  // R5
  replay_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fillReq) |=> respValid);
endmodule

// File: tb/setassoc_icache_tb.sv
`timescale 1ns/1ps
module setassoc_icache_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        reqReady;
  logic        respValid;
  logic [31:0] respData;
  logic        fillReq;
  logic [26:0] fillAddr;
  logic        fillValid;
  logic [31:0] fillData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  string       reqQ[$];

  bit          mValid [64][4];
  logic [20:0] mTag   [64][4];
  int          mStamp [64][4];
  int          stampCnt = 1;

  always #10 clk = ~clk;

  setassoc_icache u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respData(respData),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid),
    .fillData(fillData)
  );

  function automatic logic [31:0] memWord(input logic [26:0] line, input logic [2:0] w);
    return ({line, w, 2'b00} * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int w, input int b);
    return {t[20:0], s[5:0], w[2:0], b[1:0]};
  endfunction

  task automatic check(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && respValid === 1'b1) begin
      if (expQ.size() == 0)
        check(1'b0, "R9", "unexpected response", 64'(respData), 64'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(respData === e, r, "response word", 64'(respData), 64'(e));
      end
    end
  end

  function automatic int lookupModel(input logic [31:0] a);
    int hw = -1;
    for (int w = 0; w < 4; w++)
      if (mValid[a[10:5]][w] && mTag[a[10:5]][w] == a[31:11]) hw = w;
    return hw;
  endfunction

  function automatic int pickVictim(input int s);
    int v = -1;
    int best = 0;
    for (int w = 3; w >= 0; w--) if (!mValid[s][w]) v = w;
    if (v < 0) begin
      v = 0; best = mStamp[s][0];
      for (int w = 1; w < 4; w++)
        if (mStamp[s][w] < best) begin v = w; best = mStamp[s][w]; end
    end
    return v;
  endfunction

  task automatic touchModel(input logic [31:0] a, input int w);
    mStamp[a[10:5]][w] = stampCnt;
    stampCnt++;
  endtask

  task automatic installModel(input logic [31:0] a);
    int v;
    v = pickVictim(a[10:5]);
    mValid[a[10:5]][v] = 1'b1;
    mTag[a[10:5]][v]   = a[31:11];
    touchModel(a, v);
  endtask

  task automatic serveBurst(input logic [26:0] line, input int gapAt, input string r);
    for (int i = 0; i < 8; i++) begin
      if (i == gapAt) begin
        fillValid = 1'b0;
        @(negedge clk);
      end
      check(fillReq === 1'b1, "R3", "fillReq held during burst", 64'(fillReq), 64'd1);
      check(fillAddr === line, r, "fillAddr during burst", 64'(fillAddr), 64'(line));
      fillValid = 1'b1;
      fillData  = memWord(line, 3'(i));
      @(negedge clk);
    end
    fillValid = 1'b0;
    fillData  = '0;
  endtask

  task automatic access(input logic [31:0] a, input string r, input int gapAt = -1);
    int hw;
    hw = lookupModel(a);
    while (reqReady !== 1'b1) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    expQ.push_back(memWord(a[31:5], a[4:2]));
    reqQ.push_back(r);
    @(negedge clk);
    reqValid = 1'b0;
    if (hw >= 0) begin
      check(fillReq === 1'b0, r, "hit must not fetch", 64'(fillReq), 64'd0);
      touchModel(a, hw);
    end else begin
      check(fillReq === 1'b1, r, "miss must fetch", 64'(fillReq), 64'd1);
      check(reqReady === 1'b0, "R3", "stalled on miss", 64'(reqReady), 64'd0);
      check(fillAddr === a[31:5], r, "fill line address", 64'(fillAddr), 64'(a[31:5]));
      installModel(a);
      serveBurst(a[31:5], gapAt, r);
    end
  endtask

  // R9: a miss with a second request held through the whole fill
  task automatic missWithPending(input logic [31:0] a, input logic [31:0] b);
    int hwB;
    while (reqReady !== 1'b1) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    expQ.push_back(memWord(a[31:5], a[4:2]));
    reqQ.push_back("R9");
    @(negedge clk);
    check(fillReq === 1'b1, "R9", "first request misses", 64'(fillReq), 64'd1);
    installModel(a);
    reqAddr = b;
    for (int i = 0; i < 8; i++) begin
      check(reqReady === 1'b0, "R9", "not ready during fill", 64'(reqReady), 64'd0);
      fillValid = 1'b1;
      fillData  = memWord(a[31:5], 3'(i));
      @(negedge clk);
    end
    fillValid = 1'b0;
    check(reqReady === 1'b0, "R9", "not ready during replay", 64'(reqReady), 64'd0);
    hwB = lookupModel(b);
    expQ.push_back(memWord(b[31:5], b[4:2]));
    reqQ.push_back("R9");
    @(negedge clk);
    check(reqReady === 1'b1, "R9", "ready after replay", 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(fillReq === 1'b0, "R9", "held request hits", 64'(fillReq), 64'd0);
    if (hwB >= 0) touchModel(b, hwB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; fillValid = 1'b0; fillData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    check(reqReady === 1'b1, "R8", "reqReady after reset", 64'(reqReady), 64'd1);
    check(respValid === 1'b0, "R8", "respValid after reset", 64'(respValid), 64'd0);
    check(fillReq === 1'b0, "R8", "fillReq after reset", 64'(fillReq), 64'd0);

    access(mk(1, 3, 2, 0), "R8");
    access(mk(1, 3, 5, 1), "R1");
    access(mk(1, 3, 7, 3), "R2");
    // R6: empty ways fill before eviction
    access(mk(2, 3, 0, 0), "R6");
    access(mk(3, 3, 1, 0), "R6");
    access(mk(4, 3, 6, 0), "R4", 3);
    for (int t = 1; t <= 4; t++) access(mk(t, 3, t, 0), "R6");
    // R7: recency-driven victim choice
    access(mk(1, 3, 0, 0), "R7");
    access(mk(3, 3, 0, 0), "R7");
    access(mk(5, 3, 2, 0), "R7");
    access(mk(2, 3, 3, 0), "R7");
    access(mk(1, 3, 4, 0), "R7");
    access(mk(4, 3, 5, 0), "R7");
    access(mk(3, 3, 7, 0), "R7");
    access(mk(5, 3, 1, 0), "R7");
    // R1: index and upper tag bit separate lines
    access(mk(1, 4, 0, 0), "R1");
    access(mk(21'h100001, 3, 2, 0), "R1");
    // R9: pending request during fill
    missWithPending(mk(9, 7, 1, 0), mk(1, 4, 3, 0));
    // R10: stray fill strobes while idle
    fillValid = 1'b1; fillData = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    fillValid = 1'b0;
    check(fillReq === 1'b0, "R10", "no fetch from stray strobe", 64'(fillReq), 64'd0);
    check(respValid === 1'b0, "R10", "no response from stray strobe", 64'(respValid), 64'd0);
    access(mk(1, 4, 6, 0), "R10");
    access(mk(9, 7, 5, 0), "R10");
    // R5: replay after a burst with an early gap
    access(mk(6, 9, 4, 0), "R5", 0);
    access(mk(6, 9, 4, 2), "R5");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "all responses returned", 64'(expQ.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule